// File: doc/BRIEF.md
# Transmit Header Byte Aligner

The aligner sits on the read side of a transmit buffer. Each buffer element is a header followed by a payload. Both are stored as 64-bit words, and the byte at offset 0 of a word sits in bits [63:56]. Headers are written into the buffer in whole 8-byte chunks, so the real header can start several bytes into its first word. Those leading bytes are filler. The header's last word can also end in unused bytes, because the payload always starts on a new word. The aligner removes all of these filler bytes. It sends out the header and payload as one continuous stream of fully packed 64-bit words.

An element starts with a control word on its own valid/ready channel. The control word gives three values: the count of filler bytes before the header (0 to 7), the header length in bytes, and the payload length in bytes. The stored words for the element then arrive on a second valid/ready channel. The number of words is fixed by the three lengths. Output words are fully packed except the last one. The last word carries an end flag and a byte count, and its valid bytes are left-justified.

Top module: `txhdr_aligner`

## Requirements
- R1: After reset the block is idle: ctlReady is 1, inReady is 0 and outValid is 0.
- R2: A control word is taken only while the block is idle, and ctlReady and inReady are never high together. ctlPad is the filler count, ctlHdrLen the header byte count and ctlPayLen the payload byte count.
- R3: Byte offset 0 of every word is bits [63:56]. In the first header word, the ctlPad leading bytes are dropped, and the next byte is the first byte sent.
- R4: Header bytes past ctlHdrLen in the last header word are dropped. The payload begins with byte 0 of the next input word, and its first byte follows the last header byte directly in the output.
- R5: Every output word other than the last carries 8 valid bytes and has outCount equal to 0.
- R6: The last word of an element has outLast set. Its outCount equals the element's output byte count modulo 8, where 0 means 8. Its valid bytes are left-justified and all bytes after them are zero.
- R7: An element takes exactly ceil((ctlPad+ctlHdrLen)/8) header words, or none when ctlHdrLen is 0, plus ceil(ctlPayLen/8) payload words. After that, inReady goes low until the next control word.
- R8: An element with zero header length and zero payload length produces no output words. It consumes only its control word.
- R9: While outValid is high and outReady is low, the output word holds its value and inReady is low.
- R10: When input is offered every cycle and outReady stays high, inReady stays high for every word of an element.
- R11: Under any pattern of input and output stalls, the output stream of an element is exactly its header bytes followed by its payload bytes. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlValid | input | 1 | Control word offered |
| ctlReady | output | 1 | Control word taken (block idle) |
| ctlPad | input | 3 | Filler bytes before the header in its first word |
| ctlHdrLen | input | HDR_W (8) | Header length in bytes |
| ctlPayLen | input | PAY_W (14) | Payload length in bytes |
| inValid | input | 1 | Stored word offered |
| inReady | output | 1 | Stored word taken |
| inData | input | 64 | Stored word, big-endian bytes |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | 64 | Packed output word |
| outCount | output | 3 | Valid bytes in the last word, 0 meaning 8 |
| outLast | output | 1 | Last word of the element |

## Verification
A stored word taken at a clock edge updates the carry register at that same edge. Any output word it completes is visible from the following edge. When an element's last word leaves more than 8 bytes in total, the final partial word appears one edge later, from the flush step. The bench never predicts a cycle number. It drives the inputs and samples the ready and valid signals one time step after each falling edge. It counts a transfer only when valid and ready were both high there, and it compares each transferred output word with the next bytes of the expected stream. Hold behaviour is checked at the falling edge after a stalled transfer.

// File: rtl/txalign_pkg.sv
package txalign_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int WORD_W = LANES * 8;

  typedef struct packed {
    logic              load;
    logic              flush;
    logic              full;
    logic              emit;
    logic              last;
    logic [LANE_W-1:0] skip;
    logic [LANE_W:0]   take;
    logic [LANE_W-1:0] carryCnt;
    logic [LANE_W-1:0] outCount;
  } alignStrobes_t;
endpackage

// File: rtl/txalign_ctrl.sv
module txalign_ctrl
  import txalign_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int PAY_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlValid,
  output logic               ctlReady,
  input  logic [LANE_W-1:0]  ctlPad,
  input  logic [HDR_W-1:0]   ctlHdrLen,
  input  logic [PAY_W-1:0]   ctlPayLen,
  input  logic               inValid,
  output logic               inReady,
  input  logic               outValid,
  input  logic               outReady,
  output alignStrobes_t      stb
);
  localparam int TOT_W = LANE_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FLUSH} state_t;

  state_t            state;
  logic [LANE_W-1:0] padQ;
  logic              first;
  logic [HDR_W-1:0]  hdrLeft;
  logic [PAY_W-1:0]  payLeft;
  logic [LANE_W-1:0] carryCnt;

  logic              canAdv;
  logic              hdrPhase;
  logic [LANE_W-1:0] skipV;
  logic [LANE_W:0]   avail;
  logic [LANE_W:0]   takeV;
  logic              lastWord;
  logic [TOT_W-1:0]  total;
  logic              full;
  logic              accept;
  logic              needFlush;
  logic              flushGo;
  logic [TOT_W-1:0]  newCnt;

  always_comb begin
    canAdv   = !outValid || outReady;
    hdrPhase = hdrLeft != '0;
    skipV    = (hdrPhase && first) ? padQ : '0;
    avail    = (LANE_W+1)'(LANES) - (LANE_W+1)'(skipV);
    if (hdrPhase)
      takeV = (hdrLeft < HDR_W'(avail)) ? (LANE_W+1)'(hdrLeft) : avail;
    else
      takeV = (payLeft < PAY_W'(LANES)) ? (LANE_W+1)'(payLeft) : (LANE_W+1)'(LANES);
    lastWord  = hdrPhase ? (hdrLeft == HDR_W'(takeV) && payLeft == '0)
                         : (payLeft == PAY_W'(takeV));
    total     = TOT_W'(carryCnt) + TOT_W'(takeV);
    full      = total >= TOT_W'(LANES);
    accept    = (state == ST_BUSY) && inValid && canAdv;
    needFlush = lastWord && (total > TOT_W'(LANES));
    flushGo   = (state == ST_FLUSH) && canAdv;
    if (full)          newCnt = total - TOT_W'(LANES);
    else if (lastWord) newCnt = '0;
    else               newCnt = total;
  end

  always_comb begin
    ctlReady     = state == ST_IDLE;
    inReady      = (state == ST_BUSY) && canAdv;
    stb.load     = accept;
    stb.flush    = flushGo;
    stb.full     = full;
    stb.emit     = (accept && (full || lastWord)) || flushGo;
    stb.last     = flushGo || (accept && lastWord && !needFlush);
    stb.skip     = skipV;
    stb.take     = takeV;
    stb.carryCnt = carryCnt;
    if (flushGo)   stb.outCount = carryCnt;
    else if (full) stb.outCount = '0;
    else           stb.outCount = total[LANE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      padQ     <= '0;
      first    <= 1'b0;
      hdrLeft  <= '0;
      payLeft  <= '0;
      carryCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (ctlValid) begin
          padQ     <= ctlPad;
          hdrLeft  <= ctlHdrLen;
          payLeft  <= ctlPayLen;
          first    <= 1'b1;
          carryCnt <= '0;
          if (ctlHdrLen != '0 || ctlPayLen != '0) state <= ST_BUSY;
        end
        ST_BUSY: if (accept) begin
          first    <= 1'b0;
          carryCnt <= newCnt[LANE_W-1:0];
          if (hdrPhase) hdrLeft <= hdrLeft - HDR_W'(takeV);
          else          payLeft <= payLeft - PAY_W'(takeV);
          if (lastWord) state <= needFlush ? ST_FLUSH : ST_IDLE;
        end
        ST_FLUSH: if (canAdv) begin
          carryCnt <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txalign_data.sv
module txalign_data
  import txalign_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobes_t     stb,
  input  logic [WORD_W-1:0] inData,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [LANE_W-1:0] outCount,
  output logic              outLast
);
  logic [WORD_W-1:0]   carryQ;
  logic [WORD_W-1:0]   shifted;
  logic [WORD_W-1:0]   keepMask;
  logic [WORD_W-1:0]   piece;
  logic [2*WORD_W-1:0] spread;
  logic [2*WORD_W-1:0] combined;

  always_comb begin
    shifted  = inData << {stb.skip, 3'b000};
    keepMask = ~({WORD_W{1'b1}} >> {stb.take, 3'b000});
    piece    = shifted & keepMask;
    spread   = {piece, {WORD_W{1'b0}}} >> {stb.carryCnt, 3'b000};
    combined = {carryQ, {WORD_W{1'b0}}} | spread;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ   <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outCount <= '0;
      outLast  <= 1'b0;
    end else begin
      if (stb.flush) begin
        outData <= carryQ;
        carryQ  <= '0;
      end else if (stb.load) begin
        if (stb.full) begin
          outData <= combined[2*WORD_W-1:WORD_W];
          carryQ  <= combined[WORD_W-1:0];
        end else if (stb.emit) begin
          outData <= combined[2*WORD_W-1:WORD_W];
          carryQ  <= '0;
        end else begin
          carryQ  <= combined[2*WORD_W-1:WORD_W];
        end
      end
      if (stb.emit) begin
        outValid <= 1'b1;
        outCount <= stb.outCount;
        outLast  <= stb.last;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txhdr_aligner.sv
module txhdr_aligner
  import txalign_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int PAY_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlValid,
  output logic              ctlReady,
  input  logic [LANE_W-1:0] ctlPad,
  input  logic [HDR_W-1:0]  ctlHdrLen,
  input  logic [PAY_W-1:0]  ctlPayLen,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic [LANE_W-1:0] outCount,
  output logic              outLast
);
  alignStrobes_t stb;

  txalign_ctrl #(.HDR_W(HDR_W), .PAY_W(PAY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlValid(ctlValid), .ctlReady(ctlReady),
    .ctlPad(ctlPad), .ctlHdrLen(ctlHdrLen), .ctlPayLen(ctlPayLen),
    .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .stb(stb)
  );

  txalign_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outCount(outCount), .outLast(outLast)
  );
endmodule

// File: rtl/txhdr_aligner_sva.sv
module txhdr_aligner_sva
  import txalign_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ctlReady,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic [LANE_W-1:0] outCount,
  input logic              outLast
);
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outCount) && $stable(outLast)); // R9
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R9
  AST_PACKED_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |-> outCount == '0); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outCount != '0 |-> (outData << {outCount, 3'b000}) == '0); // R6
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlReady && inReady)); // R2
endmodule

bind txhdr_aligner txhdr_aligner_sva u_sva (
  .clk(clk), .rstN(rstN), .ctlReady(ctlReady), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outCount(outCount), .outLast(outLast)
);

// File: tb/tb_txhdr_aligner.sv
module tb_txhdr_aligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlValid = 1'b0;
  logic        ctlReady;
  logic [2:0]  ctlPad = '0;
  logic [7:0]  ctlHdrLen = '0;
  logic [13:0] ctlPayLen = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outData;
  logic [2:0]  outCount;
  logic        outLast;

  int checks = 0;
  int errors = 0;
  int missedReady = 0;

  always #2 clk = ~clk;

  txhdr_aligner dut (
    .clk(clk), .rstN(rstN), .ctlValid(ctlValid), .ctlReady(ctlReady),
    .ctlPad(ctlPad), .ctlHdrLen(ctlHdrLen), .ctlPayLen(ctlPayLen),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outCount(outCount), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hdrByte(int e, int i);
    return 8'((e * 7 + i * 3 + 1) & 8'hff);
  endfunction
  function automatic logic [7:0] payByte(int e, int j);
    return 8'((e * 5 + j * 11 + 8'h80) & 8'hff);
  endfunction
  function automatic logic [7:0] junk(int p);
    return 8'hA5 ^ 8'(p);
  endfunction

  task automatic runElem(input int pad, input int hdr, input int pay, input int e, input bit stall);
    logic [63:0] words[$];
    logic [7:0]  expB[$];
    int nh;
    int np;
    nh = (hdr > 0) ? (pad + hdr + 7) / 8 : 0;
    np = (pay + 7) / 8;
    for (int w = 0; w < nh; w++) begin
      logic [63:0] wd;
      for (int b = 0; b < 8; b++) begin
        int p;
        p = w * 8 + b;
        wd[63 - 8 * b -: 8] = (p >= pad && p < pad + hdr) ? hdrByte(e, p - pad) : junk(p);
      end
      words.push_back(wd);
    end
    for (int w = 0; w < np; w++) begin
      logic [63:0] wd;
      for (int b = 0; b < 8; b++) begin
        int p;
        p = w * 8 + b;
        wd[63 - 8 * b -: 8] = (p < pay) ? payByte(e, p) : junk(p + 3);
      end
      words.push_back(wd);
    end
    for (int i = 0; i < hdr; i++) expB.push_back(hdrByte(e, i));
    for (int j = 0; j < pay; j++) expB.push_back(payByte(e, j));

    fork
      begin : driver
        int idx;
        @(negedge clk);
        ctlValid = 1'b1;
        ctlPad = 3'(pad);
        ctlHdrLen = 8'(hdr);
        ctlPayLen = 14'(pay);
        #1;
        while (!ctlReady) begin
          @(negedge clk);
          #1;
        end
        @(posedge clk);
        idx = 0;
        while (idx < words.size()) begin
          @(negedge clk);
          ctlValid = 1'b0;
          inValid = stall ? ($urandom_range(3) != 0) : 1'b1;
          inData = words[idx];
          #1;
          if (idx == 0) check(ctlReady == 1'b0, "R2", "ctlReady during data", 64'(ctlReady), 64'd0);
          if (!stall && !inReady) missedReady++;
          if (inValid && inReady) idx++;
        end
        @(negedge clk);
        ctlValid = 1'b0;
        inValid = 1'b0;
        #1;
        check(inReady == 1'b0, "R7", "inReady after last word", 64'(inReady), 64'd0);
        if (words.size() == 0) begin
          repeat (3) begin
            @(negedge clk);
            #1;
            check(outValid == 1'b0, "R8", "output for empty element", 64'(outValid), 64'd0);
          end
        end
      end
      begin : monitor
        int pos;
        bit held;
        logic [63:0] heldData;
        pos = 0;
        held = 1'b0;
        heldData = '0;
        while (pos < expB.size()) begin
          @(negedge clk);
          outReady = stall ? ($urandom_range(3) != 0) : 1'b1;
          #1;
          if (held) begin
            check(outValid && outData == heldData, "R9", "held output word", outData, heldData);
            held = 1'b0;
          end
          if (outValid && !outReady) begin
            check(inReady == 1'b0, "R9", "inReady under output stall", 64'(inReady), 64'd0);
            held = 1'b1;
            heldData = outData;
          end
          if (outValid && outReady) begin
            int rem;
            int n;
            bit expLast;
            bit dataOk;
            logic [63:0] expW;
            rem = expB.size() - pos;
            n = (rem < 8) ? rem : 8;
            expLast = rem <= 8;
            expW = '0;
            for (int b = 0; b < n; b++) expW[63 - 8 * b -: 8] = expB[pos + b];
            dataOk = outData == expW;
            check(dataOk, "R3 R4 R11", "output word bytes", outData, expW);
            check(outLast == expLast, "R6", "end flag", 64'(outLast), 64'(expLast));
            if (expLast)
              check(outCount == 3'(rem % 8), "R6", "final byte count", 64'(outCount), 64'(rem % 8));
            else
              check(outCount == 3'd0, "R5", "packed word count", 64'(outCount), 64'd0);
            pos += 8;
          end
        end
        @(negedge clk);
        outReady = 1'b1;
      end
    join
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not complete", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(ctlReady == 1'b1, "R1", "ctlReady after reset", 64'(ctlReady), 64'd1);
    check(inReady == 1'b0, "R1", "inReady after reset", 64'(inReady), 64'd0);
    check(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);

    e = 0;
    for (int pad = 0; pad < 8; pad++)
      for (int hdr = 0; hdr < 18; hdr++)
        for (int pay = 0; pay < 18; pay++) begin
          runElem(pad, hdr, pay, e, 1'b1);
          e++;
        end

    missedReady = 0;
    for (int pad = 0; pad < 8; pad++)
      for (int hdr = 1; hdr < 20; hdr += 3) begin
        runElem(pad, hdr, 21, e, 1'b0);
        e++;
      end
    check(missedReady == 0, "R10", "cycles with inReady low under full flow",
          64'(missedReady), 64'd0);

    runElem(5, 0, 0, e, 1'b0);
    runElem(3, 255, 40, e + 1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule